// File: doc/BRIEF.md
# Clock Synthesizer Programming Sequencer

This block brings an integer-N clock synthesizer from an unknown setting to a locked state with its output dividers running. A single start pulse captures the pre-divider N, the feedback multiplier M, four output post-dividers and the intermediate reference frequency in kHz. The sequencer then works through the synthesizer's register bank using a one-transaction-at-a-time master port. It writes the divider words, read-modify-writes the control word, issues a go command, waits for the go bit to clear, and waits for lock. It then re-enables only the output dividers that are non-zero and waits for their acknowledge bits.

The work happens in two phases. Until lock is reported, every output divider is held in bypass and disabled. After lock, only the requested outputs are switched on, and the sequence finishes only when the acknowledge mask built from those outputs reads back complete. Each wait can end in a timeout, and the cause is reported as a distinct error code.

States:
- `S_IDLE`: waits for start.
- Write states `S_WR_CFG1`, `S_WR_CFG3`, `S_WR_CFG2A`, `S_WR_GO`, `S_WR_CFG2B`.
- Read states `S_RD_CFG2A`, `S_RD_CFG2B`.
- Polling states `S_POLL_GO`, `S_POLL_LOCK`, `S_POLL_ACK`.
- Terminal states `S_DONE` and `S_FAIL`. Each lasts one cycle and then returns to `S_IDLE`.

Transitions:
- Every transfer state advances on `bus_ack`, in the order above: CFG1, CFG3, RD_CFG2A, WR_CFG2A, GO, POLL_GO, POLL_LOCK, RD_CFG2B, WR_CFG2B, POLL_ACK.
- A polling state advances when its condition is met.
- A polling state moves to `S_FAIL` when a failed poll arrives after its time or count limit has been reached.
- `S_POLL_ACK` moves to `S_DONE` on success.

Top module: `pll_cfg_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err` and `bus_req` are low and `err_code` is 0. No request is raised while `busy` is low.
- R2: Address 0x0C receives (N-1) in bits 8:1, M in bits 20:9, the encoded divider 0 in bits 25:21 and the encoded divider 1 in bits 30:26. Address 0x14 receives the encoded divider 2 in bits 4:0 and the encoded divider 3 in bits 9:5. A divider d encodes as d-1, and 0 encodes as 0. These two writes come first, 0x0C then 0x14.
- R3: The control word at 0x10 is read. It is then written back with bit 13 (reference enable) and bit 20 (divider bypass) set, and bits 14, 16, 18, 23 and 25 cleared. All bits outside 4:1 are otherwise kept.
- R4: Bits 4:1 of that write hold a frequency select code: 3 when the reference frequency is below 1000 kHz, 4 below 1250 kHz, 5 below 1500 kHz, 6 below 1750 kHz, and 7 otherwise.
- R5: After the control write, the value 1 is written to 0x08. Address 0x08 is then read until its bit 0 is 0, and after that 0x04 is read until its bit 1 is 1. No other poll precedes lock.
- R6: After lock, 0x10 is read again and written back with bit 14 set and bit 20 cleared. Output enables for dividers 0 to 3 sit at bits 16, 18, 23 and 25, and each is set exactly when its divider is non-zero.
- R7: 0x04 is then polled until the acknowledge bits of the enabled dividers (bits 7, 8, 10, 11 for dividers 0 to 3) are all set, and then `done` pulses for one cycle. When no divider is enabled, one poll suffices.
- R8: If the acknowledge mask is still incomplete on poll number ACK_POLLS, `err` pulses with `err_code` 3.
- R9: A go or lock wait that has lasted WAIT_LIMIT cycles ends at its next failed poll with `err` and `err_code` 1 (go stuck) or 2 (no lock). The code holds until the next start.
- R10: Within a go or lock wait, the first BURST_POLLS polls are issued back to back. Every later poll follows the previous response by at least GAP_CYC cycles.
- R11: `bus_req` is a single-cycle pulse, and no new request is raised until `bus_ack` has answered the previous one.
- R12: A start pulse while busy is ignored, and the divider and frequency inputs are sampled only at the accepted start, so later changes to them do not alter the written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| n_div | input | NW | Pre-divider N (at least 1) |
| m_div | input | MW | Feedback multiplier M |
| od_div | input | 4*DW | Four output dividers, divider g at bits g*DW +: DW, 0 means unused |
| fint_khz | input | FW | Intermediate reference frequency in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 2 | 0 none, 1 go stuck, 2 no lock, 3 acknowledge timeout |
| bus_req | output | 1 | Transaction request pulse |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle response, read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
A corrupted state register shows up at the ports within one transaction, as a write to the wrong address, a skipped read, or a mis-ordered write. The write scoreboard catches this at the very next request. A corrupted captured control word or latched divider appears in the data of the following write. A wrong poll counter or gap timer shows up as altered spacing between go polls around the burst boundary, or as a change in the number of acknowledge polls before error code 3. A mis-steered error path appears as the wrong `err_code` in the cycle `err` pulses.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_CFG1,
        S_WR_CFG3,
        S_RD_CFG2A,
        S_WR_CFG2A,
        S_WR_GO,
        S_POLL_GO,
        S_POLL_LOCK,
        S_RD_CFG2B,
        S_WR_CFG2B,
        S_POLL_ACK,
        S_DONE,
        S_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        E_NONE     = 2'd0,
        E_GO_STUCK = 2'd1,
        E_NO_LOCK  = 2'd2,
        E_ACK_TMO  = 2'd3
    } seq_err_t;

    localparam logic [7:0] A_STATUS = 8'h04;
    localparam logic [7:0] A_GO     = 8'h08;
    localparam logic [7:0] A_CFG1   = 8'h0C;
    localparam logic [7:0] A_CFG2   = 8'h10;
    localparam logic [7:0] A_CFG3   = 8'h14;

    localparam logic [31:0] B_REFEN  = 32'h1 << 13;
    localparam logic [31:0] B_PHYIN  = 32'h1 << 14;
    localparam logic [31:0] B_BYPASS = 32'h1 << 20;
    localparam logic [31:0] M_FSEL   = 32'hF << 1;
    localparam logic [31:0] M_OUTEN  = (32'h1 << 16) | (32'h1 << 18) |
                                       (32'h1 << 23) | (32'h1 << 25);

    localparam int GO_BIT   = 0;
    localparam int LOCK_BIT = 1;

endpackage

// File: rtl/pll_freq_sel.sv
module pll_freq_sel #(
    parameter int FW    = 21,
    parameter int T0_KHZ = 1000,
    parameter int T1_KHZ = 1250,
    parameter int T2_KHZ = 1500,
    parameter int T3_KHZ = 1750
) (
    input  logic [FW-1:0] fint_khz,
    output logic [3:0]    fsel
);
    localparam logic [FW-1:0] T0 = FW'(T0_KHZ);
    localparam logic [FW-1:0] T1 = FW'(T1_KHZ);
    localparam logic [FW-1:0] T2 = FW'(T2_KHZ);
    localparam logic [FW-1:0] T3 = FW'(T3_KHZ);

    always_comb begin
        if (fint_khz < T0)      fsel = 4'd3;
        else if (fint_khz < T1) fsel = 4'd4;
        else if (fint_khz < T2) fsel = 4'd5;
        else if (fint_khz < T3) fsel = 4'd6;
        else                    fsel = 4'd7;
    end

    always_comb begin
        a_r4_code_range: assert (fsel >= 4'd3 && fsel <= 4'd7);
    end
endmodule

// File: rtl/pll_cfg_words.sv
module pll_cfg_words #(
    parameter int NW = 8,
    parameter int MW = 12,
    parameter int DW = 5
) (
    input  logic [NW-1:0]   n_val,
    input  logic [MW-1:0]   m_val,
    input  logic [4*DW-1:0] od_val,
    output logic [31:0]     cfg1_word,
    output logic [31:0]     cfg3_word,
    output logic [31:0]     outen_bits,
    output logic [31:0]     ack_mask
);
    localparam int ENPOS [4]  = '{16, 18, 23, 25};
    localparam int ACKPOS [4] = '{7, 8, 10, 11};

    logic [DW-1:0] enc [4];
    logic [3:0]    used;
    logic [31:0]   en_part [4];
    logic [31:0]   ack_part [4];

    for (genvar g = 0; g < 4; g++) begin : g_div
        logic [DW-1:0] raw;
        assign raw         = od_val[g*DW +: DW];
        assign used[g]     = |raw;
        assign enc[g]      = used[g] ? raw - 1'b1 : '0;
        assign en_part[g]  = 32'(used[g]) << ENPOS[g];
        assign ack_part[g] = 32'(used[g]) << ACKPOS[g];
    end

    assign cfg1_word  = (32'(n_val - 1'b1) << 1) | (32'(m_val) << 9) |
                        (32'(enc[0]) << 21) | (32'(enc[1]) << 26);
    assign cfg3_word  = 32'(enc[2]) | (32'(enc[3]) << 5);
    assign outen_bits = en_part[0] | en_part[1] | en_part[2] | en_part[3];
    assign ack_mask   = ack_part[0] | ack_part[1] | ack_part[2] | ack_part[3];
endmodule

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
    parameter int BURST_POLLS = 100,
    parameter int MAX_POLLS   = 100,
    parameter int GAP_CYC     = 64,
    parameter int WAIT_LIMIT  = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fail,
    input  logic slow_en,
    output logic issue_ok,
    output logic expired,
    output logic [$clog2(MAX_POLLS+1)-1:0] polls
);
    localparam int CW = $clog2(WAIT_LIMIT + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] LIMIT_C  = CW'(WAIT_LIMIT);
    localparam logic [PW-1:0] PMAX_C   = PW'(MAX_POLLS);
    localparam logic [PW-1:0] BURST_M1 = PW'(BURST_POLLS - 1);
    localparam logic [GW-1:0] GAP_C    = GW'(GAP_CYC);

    logic [CW-1:0] total_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            gap_q   <= '0;
            polls   <= '0;
        end else if (clear) begin
            total_q <= '0;
            gap_q   <= '0;
            polls   <= '0;
        end else begin
            if (total_q != LIMIT_C) total_q <= total_q + 1'b1;
            if (fail) begin
                if (polls != PMAX_C) polls <= polls + 1'b1;
                if (slow_en && polls >= BURST_M1) gap_q <= GAP_C;
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign issue_ok = (gap_q == '0);
    assign expired  = (total_q == LIMIT_C);

    a_r10_gap_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && slow_en && !clear && polls == BURST_M1) |=> !issue_ok);
endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
    import pll_cfg_pkg::*;
#(
    parameter int NW          = 8,
    parameter int MW          = 12,
    parameter int DW          = 5,
    parameter int FW          = 21,
    parameter int BURST_POLLS = 100,
    parameter int ACK_POLLS   = 100,
    parameter int GAP_CYC     = 64,
    parameter int WAIT_LIMIT  = 100000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   n_div,
    input  logic [MW-1:0]   m_div,
    input  logic [4*DW-1:0] od_div,
    input  logic [FW-1:0]   fint_khz,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [1:0]      err_code,
    output logic            bus_req,
    output logic            bus_we,
    output logic [7:0]      bus_addr,
    output logic [31:0]     bus_wdata,
    input  logic            bus_ack,
    input  logic [31:0]     bus_rdata
);
    localparam int MAXP = (BURST_POLLS > ACK_POLLS) ? BURST_POLLS : ACK_POLLS;
    localparam int PW   = $clog2(MAXP + 1);
    localparam logic [PW-1:0] ACK_M1 = PW'(ACK_POLLS - 1);

    seq_state_t state_q, state_d;
    seq_err_t   err_q;
    logic        issued_q;
    logic [NW-1:0]   n_q;
    logic [MW-1:0]   m_q;
    logic [4*DW-1:0] od_q;
    logic [FW-1:0]   f_q;
    logic [31:0] cfg2_q;
    logic [31:0] cfg1_w, cfg3_w, outen_w, ack_mask;
    logic [3:0]  fsel;
    logic        xfer, poll, poll_ok, fail, issue_ok, expired;
    logic [PW-1:0] polls;
    logic        accept;

    pll_freq_sel #(.FW(FW)) u_fsel (.fint_khz(f_q), .fsel(fsel));

    pll_cfg_words #(.NW(NW), .MW(MW), .DW(DW)) u_words (
        .n_val(n_q), .m_val(m_q), .od_val(od_q),
        .cfg1_word(cfg1_w), .cfg3_word(cfg3_w),
        .outen_bits(outen_w), .ack_mask(ack_mask)
    );

    pll_poll_timer #(
        .BURST_POLLS(BURST_POLLS), .MAX_POLLS(MAXP),
        .GAP_CYC(GAP_CYC), .WAIT_LIMIT(WAIT_LIMIT)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(state_d != state_q),
        .fail(fail), .slow_en(state_q != S_POLL_ACK),
        .issue_ok(issue_ok), .expired(expired), .polls(polls)
    );

    assign accept = (state_q == S_IDLE) && start;

    always_comb begin
        unique case (state_q)
            S_POLL_GO:   poll_ok = !bus_rdata[GO_BIT];
            S_POLL_LOCK: poll_ok = bus_rdata[LOCK_BIT];
            S_POLL_ACK:  poll_ok = (bus_rdata & ack_mask) == ack_mask;
            default:     poll_ok = 1'b0;
        endcase
    end

    assign fail = bus_ack && poll && !poll_ok;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_WR_CFG1;
            S_WR_CFG1:   if (bus_ack) state_d = S_WR_CFG3;
            S_WR_CFG3:   if (bus_ack) state_d = S_RD_CFG2A;
            S_RD_CFG2A:  if (bus_ack) state_d = S_WR_CFG2A;
            S_WR_CFG2A:  if (bus_ack) state_d = S_WR_GO;
            S_WR_GO:     if (bus_ack) state_d = S_POLL_GO;
            S_POLL_GO:   if (bus_ack) begin
                             if (poll_ok) state_d = S_POLL_LOCK;
                             else if (expired) state_d = S_FAIL;
                         end
            S_POLL_LOCK: if (bus_ack) begin
                             if (poll_ok) state_d = S_RD_CFG2B;
                             else if (expired) state_d = S_FAIL;
                         end
            S_RD_CFG2B:  if (bus_ack) state_d = S_WR_CFG2B;
            S_WR_CFG2B:  if (bus_ack) state_d = S_POLL_ACK;
            S_POLL_ACK:  if (bus_ack) begin
                             if (poll_ok) state_d = S_DONE;
                             else if (polls == ACK_M1) state_d = S_FAIL;
                         end
            S_DONE:      state_d = S_IDLE;
            S_FAIL:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            issued_q <= 1'b0;
            err_q    <= E_NONE;
            cfg2_q   <= '0;
            n_q      <= '0;
            m_q      <= '0;
            od_q     <= '0;
            f_q      <= '0;
        end else begin
            state_q <= state_d;
            if (bus_ack)      issued_q <= 1'b0;
            else if (bus_req) issued_q <= 1'b1;
            if (accept) begin
                n_q   <= n_div;
                m_q   <= m_div;
                od_q  <= od_div;
                f_q   <= fint_khz;
                err_q <= E_NONE;
            end
            if (bus_ack && (state_q == S_RD_CFG2A || state_q == S_RD_CFG2B))
                cfg2_q <= bus_rdata;
            if (state_d == S_FAIL && state_q != S_FAIL) begin
                if (state_q == S_POLL_GO)        err_q <= E_GO_STUCK;
                else if (state_q == S_POLL_LOCK) err_q <= E_NO_LOCK;
                else                             err_q <= E_ACK_TMO;
            end
        end
    end

    // outputs
    always_comb begin
        xfer      = 1'b1;
        poll      = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state_q)
            S_WR_CFG1:  begin bus_we = 1'b1; bus_addr = A_CFG1; bus_wdata = cfg1_w; end
            S_WR_CFG3:  begin bus_we = 1'b1; bus_addr = A_CFG3; bus_wdata = cfg3_w; end
            S_RD_CFG2A: bus_addr = A_CFG2;
            S_WR_CFG2A: begin
                bus_we    = 1'b1;
                bus_addr  = A_CFG2;
                bus_wdata = (cfg2_q & ~(M_FSEL | B_PHYIN | M_OUTEN))
                            | B_REFEN | B_BYPASS | (32'(fsel) << 1);
            end
            S_WR_GO:    begin bus_we = 1'b1; bus_addr = A_GO; bus_wdata = 32'd1; end
            S_POLL_GO:  begin bus_addr = A_GO; poll = 1'b1; end
            S_POLL_LOCK: begin bus_addr = A_STATUS; poll = 1'b1; end
            S_RD_CFG2B: bus_addr = A_CFG2;
            S_WR_CFG2B: begin
                bus_we    = 1'b1;
                bus_addr  = A_CFG2;
                bus_wdata = (cfg2_q & ~(B_BYPASS | M_OUTEN)) | B_PHYIN | outen_w;
            end
            S_POLL_ACK: begin bus_addr = A_STATUS; poll = 1'b1; end
            default:    xfer = 1'b0;
        endcase
        bus_req  = xfer && !issued_q && (!poll || issue_ok);
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        err      = (state_q == S_FAIL);
        err_code = err_q;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);
    a_r7_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_ack));
    a_r9_err_coded: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'd0));
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> busy || done || err || $stable(n_q));
endmodule

// File: tb/test_pll_cfg_seq.sv
`timescale 1ns/1ps
module test_pll_cfg_seq;
    import pll_cfg_pkg::*;

    localparam int NW = 8, MW = 12, DW = 5, FW = 21;
    localparam int BURST = 100, ACKP = 100, GAP = 20, LIMIT = 3000, LAT = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, busy, done, err, bus_req, bus_we, bus_ack;
    logic [NW-1:0] n_div;
    logic [MW-1:0] m_div;
    logic [4*DW-1:0] od_div;
    logic [FW-1:0] fint_khz;
    logic [1:0] err_code;
    logic [7:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    pll_cfg_seq #(
        .NW(NW), .MW(MW), .DW(DW), .FW(FW), .BURST_POLLS(BURST),
        .ACK_POLLS(ACKP), .GAP_CYC(GAP), .WAIT_LIMIT(LIMIT)
    ) i_pll_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .n_div(n_div), .m_div(m_div),
        .od_div(od_div), .fint_khz(fint_khz), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct { logic [7:0] a; logic [31:0] d; string req; } wr_t;
    wr_t exp_q[$];

    // responder / register model
    logic [31:0] rf [0:15];
    int  go_left, lock_left, ack_left, go_hold_k, lock_wait_k, ack_wait_k;
    bit  go_stuck, never_lock, ack_armed;
    logic [3:0] ack_dead;
    int  go_reads, st_reads;
    int  go_t [0:511];
    logic [31:0] rd;
    wr_t e;

    initial begin
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            while (bus_req) begin
                rd = '0;
                if (bus_we) begin
                    // monitor: compare against scoreboard
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected write", {bus_addr, bus_wdata}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(bus_addr == e.a && bus_wdata == e.d, e.req, "write",
                            {bus_addr, bus_wdata}, {e.a, e.d});
                    end
                    rf[bus_addr[5:2]] = bus_wdata;
                    if (bus_addr == A_GO) begin
                        go_left = go_hold_k;
                        lock_left = lock_wait_k;
                    end
                    if (bus_addr == A_CFG2 && bus_wdata[14]) begin
                        ack_armed = 1'b1;
                        ack_left = ack_wait_k;
                    end
                end else if (bus_addr == A_GO) begin
                    if (go_reads < 512) go_t[go_reads] = cyc;
                    go_reads++;
                    rd[0] = go_stuck || (go_left > 0);
                    if (go_left > 0) go_left--;
                end else if (bus_addr == A_STATUS) begin
                    st_reads++;
                    if (!never_lock) begin
                        if (lock_left == 0) rd[1] = 1'b1;
                        else lock_left--;
                    end
                    if (ack_armed) begin
                        if (ack_left == 0) begin
                            rd[7]  = rf[4][16] & !ack_dead[0];
                            rd[8]  = rf[4][18] & !ack_dead[1];
                            rd[10] = rf[4][23] & !ack_dead[2];
                            rd[11] = rf[4][25] & !ack_dead[3];
                        end else ack_left--;
                    end
                end else begin
                    rd = rf[bus_addr[5:2]];
                end
                repeat (LAT - 1) @(negedge clk);
                bus_rdata = rd;
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
            end
        end
    end

    function automatic logic [31:0] enc(input int d);
        return (d == 0) ? 32'd0 : 32'(d - 1);
    endfunction

    function automatic logic [31:0] fsel_of(input int f);
        if (f < 1000) return 3;
        if (f < 1250) return 4;
        if (f < 1500) return 5;
        if (f < 1750) return 6;
        return 7;
    endfunction

    int case_cycles;

    // driver: pushes expected writes, then runs one sequence
    task automatic run_case(input int n, input int m, input int o0, input int o1,
                            input int o2, input int o3, input int fk,
                            input logic [31:0] c2init, input int gh, input int lw,
                            input int aw, input logic [3:0] dead, input bit gstuck,
                            input bit nolock, input int exp_err, input bit disturb);
        logic [31:0] c1, c3, c2a, c2b;
        int t0;
        exp_q.delete();
        for (int i = 0; i < 16; i++) rf[i] = '0;
        rf[4] = c2init;
        go_hold_k = gh; lock_wait_k = lw; ack_wait_k = aw; ack_dead = dead;
        go_stuck = gstuck; never_lock = nolock; ack_armed = 1'b0;
        go_left = 0; lock_left = lw; ack_left = aw;
        go_reads = 0; st_reads = 0;

        c1 = (32'(n - 1) << 1) | (32'(m) << 9) | (enc(o0) << 21) | (enc(o1) << 26);
        c3 = enc(o2) | (enc(o3) << 5);
        c2a = (c2init & ~(32'h1E | (32'h1 << 14) | (32'h1 << 16) | (32'h1 << 18) |
                          (32'h1 << 23) | (32'h1 << 25)))
              | (32'h1 << 13) | (32'h1 << 20) | (fsel_of(fk) << 1);
        c2b = (c2a & ~((32'h1 << 20) | (32'h1 << 16) | (32'h1 << 18) |
                       (32'h1 << 23) | (32'h1 << 25)))
              | (32'h1 << 14) | (32'(o0 != 0) << 16) | (32'(o1 != 0) << 18)
              | (32'(o2 != 0) << 23) | (32'(o3 != 0) << 25);
        exp_q.push_back('{A_CFG1, c1, "R2"});
        exp_q.push_back('{A_CFG3, c3, "R2"});
        exp_q.push_back('{A_CFG2, c2a, "R3_R4"});
        exp_q.push_back('{A_GO, 32'd1, "R5"});
        if (exp_err == 0 || exp_err == 3) exp_q.push_back('{A_CFG2, c2b, "R6"});

        @(negedge clk);
        n_div = NW'(n); m_div = MW'(m);
        od_div = {DW'(o3), DW'(o2), DW'(o1), DW'(o0)};
        fint_khz = FW'(fk);
        start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R12: inputs change and start repeats while busy
            n_div = 8'hAA; m_div = 12'h555; od_div = '1; fint_khz = 21'd5;
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done || err) && (cyc - t0) < 3 * LIMIT) @(negedge clk);
        case_cycles = cyc - t0;
        chk(done == (exp_err == 0), "R7", "done pulse", done, exp_err == 0);
        chk(err == (exp_err != 0), "R9", "err pulse", err, exp_err != 0);
        chk(err_code == 2'(exp_err), "R9", "err_code", err_code, exp_err);
        chk(exp_q.size() == 0, "R2", "writes outstanding", exp_q.size(), 0);
        @(negedge clk);
        chk(!busy && !done && !err, "R1", "back to idle", busy, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; n_div = '0; m_div = '0; od_div = '0; fint_khz = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err && !bus_req && err_code == 0, "R1", "reset state",
            {busy, done, err, bus_req, err_code}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !bus_req, "R1", "idle after reset", {busy, bus_req}, 0);

        // R2 R4 R5 R6 R7: all dividers, divider 1 encodes as 0, fsel 3
        run_case(4, 300, 1, 7, 31, 2, 999, 32'h5A5A_A5A5, 3, 5, 2, 4'b0, 0, 0, 0, 0);
        chk(go_reads == 4, "R5", "go polls", go_reads, 4);
        chk(st_reads == 9, "R7", "status polls", st_reads, 9);

        // R12 disturbance, fsel 4 boundary, partial enables
        run_case(1, 4095, 5, 0, 3, 0, 1000, 32'hFFFF_FFFF, 0, 0, 0, 4'b0, 0, 0, 0, 1);
        chk(go_reads == 1, "R5", "go polls immediate", go_reads, 1);
        chk(st_reads == 2, "R7", "status polls immediate", st_reads, 2);

        // R7 empty mask, fsel 7 boundary
        run_case(255, 1, 0, 0, 0, 0, 1750, 32'h0, 1, 1, 5, 4'b0, 0, 0, 0, 0);
        chk(st_reads == 3, "R7", "empty mask single ack poll", st_reads, 3);

        // R8 ack timeout, fsel 5 boundary
        run_case(2, 100, 2, 2, 2, 2, 1250, 32'h0000_0F0F, 0, 2, 0, 4'b0100, 0, 0, 3, 0);
        chk(st_reads == 3 + ACKP, "R8", "ack polls before timeout", st_reads, 3 + ACKP);

        // R9 go stuck with R10 burst/gap, fsel 6
        run_case(3, 50, 1, 1, 1, 1, 1749, 32'h0, 0, 0, 0, 4'b0, 1, 0, 1, 0);
        chk(go_reads > BURST, "R10", "slow polls follow burst", go_reads, BURST + 1);
        chk(go_t[BURST-1] - go_t[BURST-2] < GAP, "R10", "burst spacing",
            go_t[BURST-1] - go_t[BURST-2], GAP - 1);
        chk(go_t[BURST] - go_t[BURST-1] >= GAP, "R10", "slow spacing",
            go_t[BURST] - go_t[BURST-1], GAP);
        chk(case_cycles >= LIMIT, "R9", "go wait lasted limit", case_cycles, LIMIT);

        // R9 no lock, fsel 7
        run_case(3, 60, 4, 0, 0, 0, 2000, 32'h0, 2, 0, 0, 4'b0, 0, 1, 2, 0);
        chk(go_reads == 3, "R5", "go polls before lock wait", go_reads, 3);
        chk(case_cycles >= LIMIT, "R9", "lock wait lasted limit", case_cycles, LIMIT);

        // recovery: code cleared by new start
        run_case(6, 200, 3, 3, 0, 9, 1400, 32'h1234_5678, 1, 0, 1, 4'b0, 0, 0, 0, 0);
        chk(err_code == 0, "R9", "code cleared", err_code, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule